// File: doc/BRIEF.md
# UART Modem Handshake and Loopback Control

This block holds the five-bit handshake control register of a UART. The register drives the active-low terminal-ready and request-to-send pins and gates the UART interrupt pin. It also selects an internal loopback mode for diagnostics. The block sits between the UART core (transmit shift register output, receiver input, interrupt request, modem status logic) and the chip pins. Software writes the register through a simple write port and reads it back on a parallel read bus.

In loopback mode the serial output pin is held idle-high and the serial input pin is cut off. The transmitter output feeds the receiver directly. Both modem output pins go inactive, and the four internal modem status signals are taken from the register bits instead of the pins. The rest of the UART keeps working as usual, so software can exercise transmit, receive and modem-status interrupts with no external wiring. Change indications are formed from whichever status source is selected. A write to the register therefore produces the same change indications as pin activity.

Top module: `modem_hs_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no writes, the register reads 0x00, dtr_n and rts_n are 1, and loopback is off.
- R2: A write with reg_wr high on a rising clock edge stores reg_wdata[4:0]. From that edge on, reg_rdata[4:0] shows the stored value and reg_rdata[7:5] always read 0.
- R3: Outside loopback (bit 4 = 0), dtr_n equals the inverse of bit 0 and rts_n equals the inverse of bit 1.
- R4: irq equals irq_req when bit 3 is 1, and is 0 when bit 3 is 0, in either mode.
- R5: Outside loopback, sout follows tx_bit and rx_bit follows sin. Internal status cts, dsr, ri and dcd are the inverses of the pins cts_n, dsr_n, ri_n and dcd_n.
- R6: In loopback, sout is 1 and rx_bit follows tx_bit, whatever sin does.
- R7: In loopback, dtr_n and rts_n are both 1 whatever bits 0 and 1 hold.
- R8: In loopback the modem input pins are ignored. dsr equals bit 0, cts equals bit 1, ri equals bit 2 and dcd equals bit 3.
- R9: Outside loopback, bit 2 changes no output.
- R10: d_cts, d_dsr and d_dcd are high in any cycle where the matching status signal differs from its value at the previous clock edge. teri is high when ri was 1 at the previous edge and is now 0. Reset clears the remembered values to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (bits 7:5 zero) |
| tx_bit | input | 1 | Transmit shift register output |
| rx_bit | output | 1 | Receiver serial input |
| sin | input | 1 | Serial input pin |
| sout | output | 1 | Serial output pin |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| dtr_n | output | 1 | Terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| irq_req | input | 1 | UART core interrupt request |
| irq | output | 1 | Gated interrupt pin |
| cts | output | 1 | Internal clear-to-send status |
| dsr | output | 1 | Internal data-set-ready status |
| ri | output | 1 | Internal ring indicator status |
| dcd | output | 1 | Internal carrier detect status |
| d_cts | output | 1 | Clear-to-send change indication |
| d_dsr | output | 1 | Data-set-ready change indication |
| d_dcd | output | 1 | Carrier detect change indication |
| teri | output | 1 | Ring indicator trailing-edge indication |

## Verification
The hardest case to reach is a change indication caused by the mode switch itself rather than by a pin or a bit. One example is entering loopback while a pin is asserted but its register bit is clear. Another is a trailing ring edge made only by writing bit 2 high and then low inside loopback. The stimulus opens with directed writes that set up these switches against fixed pin levels. It then runs a long stretch of random writes and random pin levels, so that mode entries and exits land on every mix of pin and bit values. A behavioural model checks every output on every cycle.

// File: rtl/modem_hs_ctrl.sv
module modem_hs_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tx_bit,
  output logic       rx_bit,
  input  logic       sin,
  output logic       sout,
  input  logic       cts_n,
  input  logic       dsr_n,
  input  logic       ri_n,
  input  logic       dcd_n,
  output logic       dtr_n,
  output logic       rts_n,
  input  logic       irq_req,
  output logic       irq,
  output logic       cts,
  output logic       dsr,
  output logic       ri,
  output logic       dcd,
  output logic       d_cts,
  output logic       d_dsr,
  output logic       d_dcd,
  output logic       teri
);

  localparam int B_DTR = 0;
  localparam int B_RTS = 1;
  localparam int B_RIL = 2;
  localparam int B_IEN = 3;
  localparam int B_LPB = 4;

  logic [4:0] ctl;
  logic       lpb;
  logic       p_cts, p_dsr, p_ri, p_dcd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctl <= '0;
    else if (reg_wr) ctl <= reg_wdata[4:0];

  assign lpb       = ctl[B_LPB];
  assign reg_rdata = {3'b000, ctl};

  assign sout   = lpb ? 1'b1   : tx_bit;
  assign rx_bit = lpb ? tx_bit : sin;

  assign dtr_n = lpb | ~ctl[B_DTR];
  assign rts_n = lpb | ~ctl[B_RTS];
  assign irq   = ctl[B_IEN] & irq_req;

  assign dsr = lpb ? ctl[B_DTR] : ~dsr_n;
  assign cts = lpb ? ctl[B_RTS] : ~cts_n;
  assign ri  = lpb ? ctl[B_RIL] : ~ri_n;
  assign dcd = lpb ? ctl[B_IEN] : ~dcd_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {p_cts, p_dsr, p_ri, p_dcd} <= '0;
    else        {p_cts, p_dsr, p_ri, p_dcd} <= {cts, dsr, ri, dcd};

  assign d_cts = cts ^ p_cts;
  assign d_dsr = dsr ^ p_dsr;
  assign d_dcd = dcd ^ p_dcd;
  assign teri  = p_ri & ~ri;

endmodule

module modem_hs_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       tx_bit,
  input logic       rx_bit,
  input logic       sout,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       irq,
  input logic       cts,
  input logic       ri,
  input logic       d_cts,
  input logic       teri
);

  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:5] == 3'b000);

  // R2
  write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_rdata[4:0] == $past(reg_wdata[4:0]));

  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[3] |-> !irq);

  // R6
  lpb_serial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] |-> (sout && rx_bit == tx_bit));

  // R7
  lpb_pins_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] |-> (dtr_n && rts_n));

  // R10
  cts_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (d_cts == (cts != $past(cts))));

  // R10
  ri_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (teri == ($past(ri) && !ri)));

endmodule

bind modem_hs_ctrl modem_hs_ctrl_chk u_chk (.*);

// File: tb/sim_modem_hs_ctrl.sv
`timescale 1ns/1ps
module sim_modem_hs_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic tx_bit = 1'b0, rx_bit, sin = 1'b1, sout;
  logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
  logic dtr_n, rts_n, irq_req = 1'b0, irq;
  logic cts, dsr, ri, dcd, d_cts, d_dsr, d_dcd, teri;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  modem_hs_ctrl u0 (.*);

  // reference state: register copy and remembered status {dcd,ri,dsr,cts}
  int m_reg = 0;
  int m_prev = 0;

  function automatic int status_of(int r);
    int s;
    if (r[4]) s = (r[3] << 3) | (r[2] << 2) | (r[0] << 1) | r[1];
    else      s = (int'(!dcd_n) << 3) | (int'(!ri_n) << 2) | (int'(!dsr_n) << 1) | int'(!cts_n);
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 0;
      m_prev = 0;
    end else begin
      m_prev = status_of(m_reg);
      if (reg_wr) m_reg = reg_wdata & 8'h1f;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit lb;
    int st;
    lb = m_reg[4];
    st = status_of(m_reg);
    if (!rst_n) begin
      chk("R1 rdata", reg_rdata, 0);
      chk("R1 dtr_n", dtr_n, 1);
      chk("R1 rts_n", rts_n, 1);
    end
    chk("R2 rdata", reg_rdata, m_reg);
    chk(lb ? "R7 dtr_n" : "R3 dtr_n", dtr_n, lb ? 1 : int'(!m_reg[0]));
    chk(lb ? "R7 rts_n" : "R3 rts_n", rts_n, lb ? 1 : int'(!m_reg[1]));
    chk("R4 irq", irq, int'(m_reg[3] && irq_req));
    chk(lb ? "R6 sout" : "R5 sout", sout, lb ? 1 : int'(tx_bit));
    chk(lb ? "R6 rx_bit" : "R5 rx_bit", rx_bit, lb ? int'(tx_bit) : int'(sin));
    chk(lb ? "R8 cts" : "R5 cts", cts, st & 1);
    chk(lb ? "R8 dsr" : "R5 dsr", dsr, (st >> 1) & 1);
    chk(lb ? "R8 ri" : "R9 ri", ri, (st >> 2) & 1);
    chk(lb ? "R8 dcd" : "R5 dcd", dcd, (st >> 3) & 1);
    chk("R10 d_cts", d_cts, (st ^ m_prev) & 1);
    chk("R10 d_dsr", d_dsr, ((st ^ m_prev) >> 1) & 1);
    chk("R10 d_dcd", d_dcd, ((st ^ m_prev) >> 3) & 1);
    chk("R10 teri", teri, int'(m_prev[2] && !st[2]));
  endtask

  task automatic step(bit wr, int data);
    @(negedge clk);
    compare();
    reg_wr = wr;
    reg_wdata = data[7:0];
  endtask

  task automatic rand_pins();
    tx_bit = $urandom_range(0, 1);
    sin = $urandom_range(0, 1);
    irq_req = $urandom_range(0, 1);
    if ($urandom_range(0, 3) == 0) cts_n = ~cts_n;
    if ($urandom_range(0, 3) == 0) dsr_n = ~dsr_n;
    if ($urandom_range(0, 3) == 0) ri_n = ~ri_n;
    if ($urandom_range(0, 3) == 0) dcd_n = ~dcd_n;
  endtask

  initial begin
    cts_n = 1'b0; dsr_n = 1'b0;
    for (int i = 0; i < 4; i++) step(0, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0);
    // R1/R9 idle outputs, then R3 pin drive and R2 upper bits
    step(1, 8'hE3); step(0, 0); step(0, 0);
    step(1, 8'h04); irq_req = 1'b1; step(0, 0);
    // R4 gate open
    step(1, 8'h08); step(0, 0);
    // R8/R10 enter loopback with pins asserted and bits clear
    step(1, 8'h10); step(0, 0); sin = 1'b0; tx_bit = 1'b1; step(0, 0);
    // R10 trailing ring edge made only by register writes
    step(1, 8'h14); step(0, 0); step(1, 8'h10); step(0, 0);
    step(1, 8'h1F); step(0, 0); step(1, 8'h00); step(0, 0);
    for (int i = 0; i < 4000; i++) begin
      rand_pins();
      if ($urandom_range(0, 3) == 0) step(1, $urandom_range(0, 255));
      else step(0, 0);
    end
    step(0, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule